// File: doc/BRIEF.md
# Processor Control Register Update Unit

This block owns the three paging and mode control registers of a processor core (the mode register at index 0, the page-table base at index 3 and the feature-enable register at index 4) together with the address-line-20 gate. Every write is examined against the value it replaces. From that comparison the block decides whether the address translation cache must be emptied completely, emptied except for global entries, or left alone. It also derives the hidden mode flags that the rest of the core reads on every instruction.

Each register has its own write strobe and data bus. A write is sampled on a rising clock edge, and the new value is visible on the outputs from that edge onward. The flush request that belongs to the write is a registered pulse that appears in the same cycle as the new value. The A20 gate is sampled every cycle. A change of its state updates the address mask and requests a full flush. Mode switches into or out of 64-bit operation are not handled here.

Top module: `cr_update_unit`

## Requirements
- R1: After a synchronous reset, the registers read as follows: register 0 is 0x60000010, register 3 is 0, register 4 is 0 and the A20 mask is 0xFFFFFFFF. The hidden flags read protected 0, segment-add 1, the three FPU flags 0 and SIMD-save 0. Both flush outputs are 0.
- R2: A write to register 0 stores the written data, except that bit 4 is always stored as 1. The stored value appears on `cr0_o` after the sampling edge.
- R3: `hf_prot_o` equals stored register 0 bit 0. `hf_segadd_o` is 1 exactly when bit 0 is 0.
- R4: `hf_mp_o`, `hf_em_o` and `hf_ts_o` equal stored register 0 bits 1, 2 and 3 respectively.
- R5: A register 0 write that changes bit 31, bit 16 or bit 0 produces `flush_all_o` high for the cycle after the sampling edge. A write that changes only other bits produces no flush.
- R6: A write to register 3 stores its data. It produces `flush_nonglobal_o` for one cycle only if bit 31 of register 0, as held before that edge, is 1.
- R7: A register 4 write that changes bit 7, bit 5 or bit 4 produces `flush_all_o` for one cycle. Changes to other bits produce no flush.
- R8: Register 4 bit 9 is stored as 0 when `simd_present_i` is low at the write. `hf_simd_save_o` equals the stored bit 9.
- R9: `a20_mask_o` equals 0xFFEFFFFF OR (gate << 20), using the gate sampled at the previous edge. A change of the sampled gate produces `flush_all_o` for one cycle.
- R10: When a full-flush cause and a non-global cause occur at the same edge, only `flush_all_o` pulses. The two flush outputs are never high together, and each goes high for exactly the cycles that follow a qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr0_we_i | input | 1 | Write strobe for register 0 |
| cr0_wdata_i | input | 32 | Write data for register 0 |
| cr3_we_i | input | 1 | Write strobe for register 3 |
| cr3_wdata_i | input | 32 | Write data for register 3 |
| cr4_we_i | input | 1 | Write strobe for register 4 |
| cr4_wdata_i | input | 32 | Write data for register 4 |
| a20_gate_i | input | 1 | Address line 20 gate level |
| simd_present_i | input | 1 | SIMD extensions are implemented |
| cr0_o | output | 32 | Stored register 0 |
| cr3_o | output | 32 | Stored register 3 |
| cr4_o | output | 32 | Stored register 4 |
| a20_mask_o | output | 32 | Physical address mask |
| hf_prot_o | output | 1 | Hidden protected-mode flag |
| hf_segadd_o | output | 1 | Hidden segment-base-add flag |
| hf_mp_o | output | 1 | Hidden FPU monitor flag |
| hf_em_o | output | 1 | Hidden FPU emulate flag |
| hf_ts_o | output | 1 | Hidden FPU task-switched flag |
| hf_simd_save_o | output | 1 | Hidden SIMD save-enable flag |
| flush_all_o | output | 1 | Full translation cache flush pulse |
| flush_nonglobal_o | output | 1 | Non-global flush pulse |

## Verification
The registers and their derived flags are visible at the ports, so a wrong stored bit shows on `cr0_o`, `cr4_o` or a hidden flag in the first cycle after the faulty write. A wrong comparison state shows up differently: a corrupted A20 state or a stale register 0 paging bit appears as a missing or spurious flush pulse on the next write or gate toggle. The bench therefore keeps its own model of every register and compares all outputs on every cycle. The stimulus reaches each flush-causing bit both alone and together with non-causing bits.

// File: rtl/cr_ctl_pkg.sv
package cr_ctl_pkg;

    localparam int XLEN = 32;

    // Bit positions the rest of the core decodes
    localparam int B_PE    = 0;
    localparam int B_MP    = 1;
    localparam int B_EM    = 2;
    localparam int B_TS    = 3;
    localparam int B_ET    = 4;
    localparam int B_WP    = 16;
    localparam int B_PG    = 31;
    localparam int B_PSE   = 4;
    localparam int B_PAE   = 5;
    localparam int B_PGE   = 7;
    localparam int B_SIMDS = 9;

    localparam logic [XLEN-1:0] CR0_RESET = 32'h6000_0010;

    localparam logic [XLEN-1:0] CR0_FLUSH_MASK =
        (32'd1 << B_PG) | (32'd1 << B_WP) | (32'd1 << B_PE);
    localparam logic [XLEN-1:0] CR4_FLUSH_MASK =
        (32'd1 << B_PGE) | (32'd1 << B_PAE) | (32'd1 << B_PSE);

    typedef struct packed {
        logic prot;
        logic segadd;
        logic mp;
        logic em;
        logic ts;
    } mode_flags_t;

    typedef enum logic [1:0] {
        FL_NONE      = 2'd0,
        FL_NONGLOBAL = 2'd1,
        FL_FULL      = 2'd2
    } flush_kind_e;

    function automatic logic group_changed(input logic [XLEN-1:0] old_v,
                                           input logic [XLEN-1:0] new_v,
                                           input logic [XLEN-1:0] grp);
        return |((old_v ^ new_v) & grp);
    endfunction

endpackage

// File: rtl/cr0_ctl.sv
module cr0_ctl
    import cr_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] cr0_q,
    output logic            full_req,
    output mode_flags_t     flags
);
    logic [XLEN-1:0] next_val;

    always_comb begin
        next_val       = wdata;
        next_val[B_ET] = 1'b1;
    end

    assign full_req = we && group_changed(cr0_q, wdata, CR0_FLUSH_MASK);

    always_ff @(posedge clk) begin
        if (rst) cr0_q <= CR0_RESET;
        else if (we) cr0_q <= next_val;
    end

    always_comb begin
        flags.prot   = cr0_q[B_PE];
        flags.segadd = ~cr0_q[B_PE];
        flags.mp     = cr0_q[B_MP];
        flags.em     = cr0_q[B_EM];
        flags.ts     = cr0_q[B_TS];
    end

    p_et_forced_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> cr0_q[B_ET]);
    p_prot_follows_r3: assert property (@(posedge clk) disable iff (rst)
        we |=> (flags.prot == $past(wdata[B_PE])) && (flags.segadd != flags.prot));
    p_fpu_follows_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> (flags.ts == $past(wdata[B_TS])) && (flags.mp == $past(wdata[B_MP])));
endmodule

// File: rtl/cr4_ctl.sv
module cr4_ctl
    import cr_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    input  logic            simd_present,
    output logic [XLEN-1:0] cr4_q,
    output logic            full_req,
    output logic            simd_save
);
    logic [XLEN-1:0] next_val;

    always_comb begin
        next_val          = wdata;
        next_val[B_SIMDS] = wdata[B_SIMDS] & simd_present;
    end

    assign full_req  = we && group_changed(cr4_q, wdata, CR4_FLUSH_MASK);
    assign simd_save = cr4_q[B_SIMDS];

    always_ff @(posedge clk) begin
        if (rst) cr4_q <= '0;
        else if (we) cr4_q <= next_val;
    end

    p_simd_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (we && !simd_present) |=> !simd_save);
endmodule

// File: rtl/a20_ctl.sv
module a20_ctl #(
    parameter int ADDR_W  = 32,
    parameter int GATE_POS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    output logic [ADDR_W-1:0] mask,
    output logic              change_req
);
    localparam logic [ADDR_W-1:0] GATE_BIT = ADDR_W'(1) << GATE_POS;
    localparam logic [ADDR_W-1:0] BASE     = ~GATE_BIT;

    logic state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b1;
        else     state_q <= gate;
    end

    assign change_req = (gate != state_q);
    assign mask       = BASE | (state_q ? GATE_BIT : '0);

    p_mask_tracks_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mask[GATE_POS] == $past(gate)));
endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit
    import cr_ctl_pkg::*;
#(
    parameter int A20_POS = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cr0_we_i,
    input  logic [XLEN-1:0] cr0_wdata_i,
    input  logic            cr3_we_i,
    input  logic [XLEN-1:0] cr3_wdata_i,
    input  logic            cr4_we_i,
    input  logic [XLEN-1:0] cr4_wdata_i,
    input  logic            a20_gate_i,
    input  logic            simd_present_i,
    output logic [XLEN-1:0] cr0_o,
    output logic [XLEN-1:0] cr3_o,
    output logic [XLEN-1:0] cr4_o,
    output logic [XLEN-1:0] a20_mask_o,
    output logic            hf_prot_o,
    output logic            hf_segadd_o,
    output logic            hf_mp_o,
    output logic            hf_em_o,
    output logic            hf_ts_o,
    output logic            hf_simd_save_o,
    output logic            flush_all_o,
    output logic            flush_nonglobal_o
);
    mode_flags_t     mflags;
    logic            cr0_full, cr4_full, a20_full;
    logic [XLEN-1:0] cr3_q;
    flush_kind_e     kind_d, kind_q;

    cr0_ctl u_cr0 (
        .clk(clk), .rst(rst), .we(cr0_we_i), .wdata(cr0_wdata_i),
        .cr0_q(cr0_o), .full_req(cr0_full), .flags(mflags)
    );

    cr4_ctl u_cr4 (
        .clk(clk), .rst(rst), .we(cr4_we_i), .wdata(cr4_wdata_i),
        .simd_present(simd_present_i), .cr4_q(cr4_o),
        .full_req(cr4_full), .simd_save(hf_simd_save_o)
    );

    a20_ctl #(.ADDR_W(XLEN), .GATE_POS(A20_POS)) u_a20 (
        .clk(clk), .rst(rst), .gate(a20_gate_i),
        .mask(a20_mask_o), .change_req(a20_full)
    );

    always_ff @(posedge clk) begin
        if (rst) cr3_q <= '0;
        else if (cr3_we_i) cr3_q <= cr3_wdata_i;
    end
    assign cr3_o = cr3_q;

    // Full flush outranks the non-global one
    always_comb begin
        if (cr0_full || cr4_full || a20_full)   kind_d = FL_FULL;
        else if (cr3_we_i && cr0_o[B_PG])       kind_d = FL_NONGLOBAL;
        else                                    kind_d = FL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) kind_q <= FL_NONE;
        else     kind_q <= kind_d;
    end

    assign flush_all_o       = (kind_q == FL_FULL);
    assign flush_nonglobal_o = (kind_q == FL_NONGLOBAL);

    assign hf_prot_o   = mflags.prot;
    assign hf_segadd_o = mflags.segadd;
    assign hf_mp_o     = mflags.mp;
    assign hf_em_o     = mflags.em;
    assign hf_ts_o     = mflags.ts;

    p_flush_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({flush_all_o, flush_nonglobal_o}) <= 1);
    p_cr3_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (cr3_we_i && cr0_o[B_PG] && !cr0_we_i && !cr4_we_i && (a20_gate_i == a20_mask_o[A20_POS]))
        |=> flush_nonglobal_o);
    p_cr3_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (cr3_we_i && !cr0_o[B_PG] && !cr0_we_i && !cr4_we_i && (a20_gate_i == a20_mask_o[A20_POS]))
        |=> !flush_nonglobal_o && !flush_all_o);
    p_a20_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (a20_gate_i != a20_mask_o[A20_POS]) |=> flush_all_o);
    p_cr0_flush_r5: assert property (@(posedge clk) disable iff (rst)
        (cr0_we_i && (cr0_wdata_i[B_PG] != cr0_o[B_PG])) |=> flush_all_o);
    p_cr4_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (cr4_we_i && (cr4_wdata_i[B_PAE] != cr4_o[B_PAE])) |=> flush_all_o);
endmodule

// File: tb/cr_update_unit_bench.sv
`timescale 1ns/1ps
module cr_update_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cr0_we, cr3_we, cr4_we, gate, simd;
    logic [31:0] cr0_wd, cr3_wd, cr4_wd;
    logic [31:0] cr0, cr3, cr4, mask;
    logic        prot, segadd, mp, em, ts, simds, fall, fng;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cr_update_unit u_cr_update_unit (
        .clk(clk), .rst(rst),
        .cr0_we_i(cr0_we), .cr0_wdata_i(cr0_wd),
        .cr3_we_i(cr3_we), .cr3_wdata_i(cr3_wd),
        .cr4_we_i(cr4_we), .cr4_wdata_i(cr4_wd),
        .a20_gate_i(gate), .simd_present_i(simd),
        .cr0_o(cr0), .cr3_o(cr3), .cr4_o(cr4), .a20_mask_o(mask),
        .hf_prot_o(prot), .hf_segadd_o(segadd), .hf_mp_o(mp), .hf_em_o(em),
        .hf_ts_o(ts), .hf_simd_save_o(simds),
        .flush_all_o(fall), .flush_nonglobal_o(fng)
    );

    // Behavioural reference model
    logic [31:0] m_cr0, m_cr3, m_cr4;
    bit          m_gate, m_fa, m_fn;
    bit          compare_on = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cr0 = 32'h6000_0010; m_cr3 = 0; m_cr4 = 0;
            m_gate = 1; m_fa = 0; m_fn = 0;
        end else begin
            bit full;
            full = (gate != m_gate);
            if (cr0_we && (((cr0_wd ^ m_cr0) & 32'h8001_0001) != 0)) full = 1;
            if (cr4_we && (((cr4_wd ^ m_cr4) & 32'h0000_00B0) != 0)) full = 1;
            m_fa = full;
            m_fn = !full && cr3_we && m_cr0[31];
            if (cr0_we) m_cr0 = cr0_wd | 32'h10;
            if (cr3_we) m_cr3 = cr3_wd;
            if (cr4_we) m_cr4 = simd ? cr4_wd : (cr4_wd & ~32'h200);
            m_gate = gate;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            chk("R2 cr0", cr0, m_cr0);
            chk("R6 cr3", cr3, m_cr3);
            chk("R7 cr4", cr4, m_cr4);
            chk("R9 a20 mask", mask, 32'hFFEF_FFFF | (32'(m_gate) << 20));
            chk("R3 prot/segadd", {30'd0, prot, segadd}, {30'd0, m_cr0[0], ~m_cr0[0]});
            chk("R4 fpu flags", {29'd0, ts, em, mp}, {29'd0, m_cr0[3:1]});
            chk("R8 simd save", {31'd0, simds}, {31'd0, m_cr4[9]});
            chk("R5/R7/R9/R10 flush_all", {31'd0, fall}, {31'd0, m_fa});
            chk("R6/R10 flush_nonglobal", {31'd0, fng}, {31'd0, m_fn});
        end
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cr0_we = 0; cr3_we = 0; cr4_we = 0;
        end
    endtask

    task automatic w0(input logic [31:0] d);
        @(negedge clk); cr0_we = 1; cr0_wd = d; cr3_we = 0; cr4_we = 0;
        @(negedge clk); cr0_we = 0;
    endtask
    task automatic w3(input logic [31:0] d);
        @(negedge clk); cr3_we = 1; cr3_wd = d; cr0_we = 0; cr4_we = 0;
        @(negedge clk); cr3_we = 0;
    endtask
    task automatic w4(input logic [31:0] d);
        @(negedge clk); cr4_we = 1; cr4_wd = d; cr0_we = 0; cr3_we = 0;
        @(negedge clk); cr4_we = 0;
    endtask

    initial begin
        rst = 1; cr0_we = 0; cr3_we = 0; cr4_we = 0; gate = 1; simd = 1;
        cr0_wd = 0; cr3_wd = 0; cr4_wd = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state against literal values
        chk("R1 cr0 reset", cr0, 32'h6000_0010);
        chk("R1 cr3 reset", cr3, 0);
        chk("R1 cr4 reset", cr4, 0);
        chk("R1 mask reset", mask, 32'hFFFF_FFFF);
        chk("R1 flags reset", {26'd0, prot, segadd, mp, em, ts, simds}, 32'b010000);
        chk("R1 flush reset", {30'd0, fall, fng}, 0);
        compare_on = 1;

        w0(32'h6000_0000);            // R2: bit4 forced, no flush group change
        w0(32'h6000_000E);            // R4: fpu bits, no flush (R5)
        w0(32'h6000_0001);            // R5: PE change -> full flush
        w3(32'h0000_1000);            // R6: paging off -> no flush
        w0(32'h8001_0001);            // R5: PG + WP
        w3(32'h0000_2000);            // R6: paging on -> non-global
        w4(32'h0000_0200);            // R8 with SIMD present, no flush
        simd = 0;
        w4(32'h0000_0220);            // R8 masked, R7 PAE change
        w4(32'h0000_0300);            // R7 other bits only, PAE back -> flush
        simd = 1;
        w4(32'h0000_0080);            // R7 PGE
        // R10: cr3 write and cr0 flush change at the same edge
        @(negedge clk); cr0_we = 1; cr0_wd = 32'h0001_0001; cr3_we = 1; cr3_wd = 32'h3000;
        @(negedge clk); cr0_we = 0; cr3_we = 0;
        w0(32'h8001_0001);
        // R10: cr3 write with a20 toggle at same edge
        @(negedge clk); cr3_we = 1; cr3_wd = 32'h4000; gate = 0;
        @(negedge clk); cr3_we = 0;
        idle(2);
        gate = 1; idle(1);              // R9 toggle back
        w3(32'h5000); w3(32'h6000);     // back-to-back R6 pulses
        idle(2);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            cr0_we = ($urandom % 3) == 0; cr0_wd = $urandom;
            cr3_we = ($urandom % 3) == 0; cr3_wd = $urandom;
            cr4_we = ($urandom % 3) == 0; cr4_wd = $urandom;
            gate = ($urandom % 5) != 0;  simd = $urandom % 2;
        end
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule